// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block controls the deepest sleep state of a small controller. Software raises a one-cycle power-down request; after a short entry delay the block withdraws the core clock enable and waits. The block itself runs from an always-on clock, so it can watch two external wake lines (an external interrupt input and a serial receive input) while the core is stopped. Interrupts and timers cannot end the sleep; only a qualified falling edge on a selected line, or the hardware reset input, can.

Which lines may wake the device, and whether the wake is a fast resume or a full start-up, are captured at the moment of the request. A wake line must first be seen high and then stay low for a programmable number of cycles; shorter low pulses are discarded. The fast resume waits for the regulator and the PLL and keeps the pins held. The full start-up additionally waits for the flash and a boot ROM interval, drives a system reset throughout, and on completion sets a sticky wake indication flag. The hardware reset input aborts any sequence and forces the full start-up. Stage waits are counted in microsecond ticks; the analog blocks are represented by ready inputs.

Top module: `pd_wake_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it: clk_en=1, pd_active=0, sys_rst=0, hold_pins=0, wake_flag=0.
- R2: A pd_req seen while running keeps clk_en=1 for ENTRY_DLY more cycles; then clk_en=0 and pd_active=1.
- R3: wsrc_sel (bit 0 = external interrupt line, bit 1 = serial receive line) and wake_full are captured with pd_req; changes to them later have no effect until the next request.
- R4: Only a selected line can wake; with wsrc_sel=2'b11 either line wakes; with 2'b00 only hw_rst ends power-down.
- R5: Wake needs the selected line seen high during power-down and then low for QUAL_CYC consecutive cycles; shorter low pulses leave pd_active=1.
- R6: With wake_full=0 the wake runs regulator then PLL stages with hold_pins=1 and sys_rst=0, then clk_en returns to 1 with wake_flag unchanged.
- R7: With wake_full=1 the wake runs regulator, PLL, flash and boot stages with sys_rst=1 and hold_pins=0; when clk_en returns, wake_flag becomes 1 in the same cycle.
- R8: The regulator stage ends only after REG_US ticks with vreg_ok high; the PLL stage ends on pll_lock or after PLL_US ticks; the flash stage needs FLASH_US ticks and flash_rdy; the boot stage lasts BOOT_US ticks.
- R9: hw_rst in any state forces the full start-up with sys_rst=1 from the next cycle; it does not set wake_flag.
- R10: wake_flag is cleared only by wkflag_clr or rst_n; a set in the same cycle as a clear wins.
- R11: clk_en stays 0 from power-down entry until the wake sequence ends; pd_req is ignored outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| hw_rst | input | 1 | Hardware reset request, active high, synchronous |
| pd_req | input | 1 | Software power-down request pulse |
| wsrc_sel | input | 2 | Wake line enables: bit 0 interrupt line, bit 1 receive line |
| wake_full | input | 1 | 1 selects full start-up on wake, 0 fast resume |
| ext_irq_in | input | 1 | External interrupt wake line, idle high |
| ser_rx_in | input | 1 | Serial receive wake line, idle high |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| vreg_ok | input | 1 | Regulator stable |
| pll_lock | input | 1 | PLL locked |
| flash_rdy | input | 1 | Flash ready to read |
| wkflag_clr | input | 1 | Software clear of the wake flag |
| clk_en | output | 1 | Core clock enable |
| pd_active | output | 1 | In power-down, waiting for a wake |
| sys_rst | output | 1 | System reset during full start-up |
| hold_pins | output | 1 | Pin states frozen |
| wake_flag | output | 1 | Sticky flag: last start-up came from a pin wake |

## Verification
The assertions assume hw_rst, pd_req and wkflag_clr are synchronous to clk and that wake lines are already synchronised, so a level seen at one edge is the level the counters use. They also take us_tick as a single-cycle pulse. The stimulus changes every input one time unit after a rising edge, drives ticks from a free counter, and brings wake lines high before each power-down so the edge qualification can be exercised with pulses both shorter and longer than the window.

// File: rtl/pd_wake_seq.sv
module pd_wake_seq #(
  parameter int ENTRY_DLY = 2,
  parameter int QUAL_CYC  = 25,
  parameter int REG_US    = 150,
  parameter int PLL_US    = 200,
  parameter int FLASH_US  = 160,
  parameter int BOOT_US   = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_rst,
  input  logic       pd_req,
  input  logic [1:0] wsrc_sel,
  input  logic       wake_full,
  input  logic       ext_irq_in,
  input  logic       ser_rx_in,
  input  logic       us_tick,
  input  logic       vreg_ok,
  input  logic       pll_lock,
  input  logic       flash_rdy,
  input  logic       wkflag_clr,
  output logic       clk_en,
  output logic       pd_active,
  output logic       sys_rst,
  output logic       hold_pins,
  output logic       wake_flag
);
  localparam int M1   = (REG_US > PLL_US) ? REG_US : PLL_US;
  localparam int M2   = (FLASH_US > BOOT_US) ? FLASH_US : BOOT_US;
  localparam int MXUS = (M1 > M2) ? M1 : M2;
  localparam int UW   = $clog2(MXUS + 1);
  localparam int QW   = $clog2(QUAL_CYC + 1);
  localparam int DW   = $clog2(ENTRY_DLY + 1);
  localparam logic [UW-1:0] REG_L   = UW'(REG_US);
  localparam logic [UW-1:0] PLL_L   = UW'(PLL_US);
  localparam logic [UW-1:0] FLASH_L = UW'(FLASH_US);
  localparam logic [UW-1:0] BOOT_L  = UW'(BOOT_US);
  localparam logic [UW-1:0] MX_L    = UW'(MXUS);
  localparam logic [QW-1:0] QEND    = QW'(QUAL_CYC - 1);
  localparam logic [DW-1:0] DEND    = DW'(ENTRY_DLY - 1);

  typedef enum logic [2:0] {S_RUN, S_ARM, S_PD, S_REG, S_PLL, S_FLASH, S_BOOT} st_t;

  st_t           st;
  logic [1:0]    sel_q;
  logic          full_q, rpath, from_wake, seen_hi;
  logic [QW-1:0] qcnt;
  logic [UW-1:0] ucnt;
  logic [DW-1:0] dcnt;
  logic          low_det, done, flag_set;

  assign low_det = (sel_q[0] & ~ext_irq_in) | (sel_q[1] & ~ser_rx_in);

  always_comb begin
    case (st)
      S_REG:   done = (ucnt >= REG_L) && vreg_ok;
      S_PLL:   done = pll_lock || (ucnt >= PLL_L);
      S_FLASH: done = (ucnt >= FLASH_L) && flash_rdy;
      S_BOOT:  done = (ucnt >= BOOT_L);
      default: done = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN; sel_q <= '0; full_q <= 1'b0; rpath <= 1'b0; from_wake <= 1'b0;
      seen_hi <= 1'b0; qcnt <= '0; ucnt <= '0; dcnt <= '0;
    end else if (hw_rst) begin
      st <= S_REG; rpath <= 1'b1; from_wake <= 1'b0; ucnt <= '0;
    end else begin
      case (st)
        S_RUN: if (pd_req) begin
          st <= S_ARM; sel_q <= wsrc_sel; full_q <= wake_full; dcnt <= '0;
        end
        S_ARM: if (dcnt == DEND) begin
          st <= S_PD; seen_hi <= 1'b0; qcnt <= '0;
        end else dcnt <= dcnt + 1'b1;
        S_PD: if (!low_det) begin
          seen_hi <= 1'b1; qcnt <= '0;
        end else if (seen_hi) begin
          if (qcnt == QEND) begin
            st <= S_REG; rpath <= full_q; from_wake <= full_q; ucnt <= '0;
          end else qcnt <= qcnt + 1'b1;
        end
        default: if (done) begin
          ucnt <= '0;
          case (st)
            S_REG:   st <= S_PLL;
            S_PLL:   st <= rpath ? S_FLASH : S_RUN;
            S_FLASH: st <= S_BOOT;
            default: st <= S_RUN;
          endcase
        end else if (us_tick && ucnt != MX_L) ucnt <= ucnt + 1'b1;
      endcase
    end
  end

  assign flag_set = (st == S_BOOT) && done && from_wake && !hw_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wake_flag <= 1'b0;
    else if (flag_set)   wake_flag <= 1'b1;
    else if (wkflag_clr) wake_flag <= 1'b0;
  end

  assign clk_en    = (st == S_RUN) || (st == S_ARM);
  assign pd_active = (st == S_PD);
  assign sys_rst   = rpath && (st == S_REG || st == S_PLL || st == S_FLASH || st == S_BOOT);
  assign hold_pins = (st == S_PD) || (!rpath && (st == S_REG || st == S_PLL));

  a_r9_hwrst_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> sys_rst);
  a_r5_high_line_stays_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PD && !low_det && !hw_rst) |=> pd_active);
  a_r2_entry_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && pd_req && !hw_rst) |=> (clk_en && !pd_active));
  a_r10_flag_clear_only_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_flag) |-> $past(wkflag_clr));
  a_r7_flag_rises_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> (clk_en && !sys_rst));
  a_r11_no_clock_after_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> !clk_en);
endmodule

// File: tb/pd_wake_seq_tb_top.sv
module pd_wake_seq_tb_top;
  localparam int ENTRY = 2, QUAL = 5, RUS = 3, PUS = 4, FUS = 2, BUS = 3;

  logic clk = 0, rst_n = 0, hw_rst = 0, pd_req = 0, wake_full = 0;
  logic [1:0] wsrc_sel = 0;
  logic ext_irq_in = 1, ser_rx_in = 1, us_tick = 0;
  logic vreg_ok = 1, pll_lock = 1, flash_rdy = 1, wkflag_clr = 0;
  logic clk_en, pd_active, sys_rst, hold_pins, wake_flag;
  int n_chk = 0, n_bad = 0, tc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pd_wake_seq #(.ENTRY_DLY(ENTRY), .QUAL_CYC(QUAL), .REG_US(RUS), .PLL_US(PUS),
                .FLASH_US(FUS), .BOOT_US(BUS)) dut_i (
    .clk, .rst_n, .hw_rst, .pd_req, .wsrc_sel, .wake_full, .ext_irq_in, .ser_rx_in,
    .us_tick, .vreg_ok, .pll_lock, .flash_rdy, .wkflag_clr,
    .clk_en, .pd_active, .sys_rst, .hold_pins, .wake_flag);

  always @(posedge clk) begin
    #1; tc++; us_tick = (tc % 4 == 0);
  end

  // behavioural model: 0 run,1 entry,2 sleep,3 regulator,4 pll,5 flash,6 boot
  int ms = 0, md = 0, mq = 0, mu = 0;
  bit msel0, msel1, mfull, mrp, mwk, mseen, mflag;
  always @(posedge clk) begin
    bit lo, fin, setf;
    if (!rst_n) begin
      ms = 0; md = 0; mq = 0; mu = 0; msel0 = 0; msel1 = 0; mfull = 0;
      mrp = 0; mwk = 0; mseen = 0; mflag = 0;
    end else begin
      setf = 0;
      lo = (msel0 && !ext_irq_in) || (msel1 && !ser_rx_in);
      fin = (ms == 3 && mu >= RUS && vreg_ok) || (ms == 4 && (pll_lock || mu >= PUS)) ||
            (ms == 5 && mu >= FUS && flash_rdy) || (ms == 6 && mu >= BUS);
      if (hw_rst) begin ms = 3; mrp = 1; mwk = 0; mu = 0; end
      else if (ms == 0) begin
        if (pd_req) begin ms = 1; md = 0; msel0 = wsrc_sel[0]; msel1 = wsrc_sel[1]; mfull = wake_full; end
      end else if (ms == 1) begin
        md++; if (md == ENTRY) begin ms = 2; mseen = 0; mq = 0; end
      end else if (ms == 2) begin
        if (!lo) begin mseen = 1; mq = 0; end
        else if (mseen) begin
          mq++; if (mq == QUAL) begin ms = 3; mrp = mfull; mwk = mfull; mu = 0; end
        end
      end else if (fin) begin
        if (ms == 6 && mwk) setf = 1;
        mu = 0;
        ms = (ms == 4) ? (mrp ? 5 : 0) : (ms == 6 ? 0 : ms + 1);
      end else if (us_tick) mu++;
      if (setf) mflag = 1; else if (wkflag_clr) mflag = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R11 clk_en", clk_en, (ms == 0 || ms == 1));
    chk("R2 pd_active", pd_active, ms == 2);
    chk("R7 sys_rst", sys_rst, mrp && ms >= 3);
    chk("R6 hold_pins", hold_pins, ms == 2 || (!mrp && (ms == 3 || ms == 4)));
    chk("R10 wake_flag", wake_flag, mflag);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sleep(logic [1:0] s, logic f);
    wsrc_sel = s; wake_full = f; pd_req = 1; cyc(1); pd_req = 0;
  endtask

  task automatic wait_run();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (clk_en) break;
    end
    cyc(1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    @(negedge clk);
    chk("R1 reset clk_en", clk_en, 1); chk("R1 reset pd", pd_active, 0);
    chk("R1 reset sys_rst", sys_rst, 0); chk("R1 reset flag", wake_flag, 0);
    rst_n = 1; cyc(2);

    sleep(2'b01, 0);
    @(negedge clk); chk("R2 clock still on after request", clk_en, 1);
    cyc(ENTRY + 2);
    chk("R2 sleeping", pd_active, 1);
    ext_irq_in = 0; cyc(QUAL - 1); ext_irq_in = 1; cyc(3);
    chk("R5 short pulse ignored", pd_active, 1);
    ser_rx_in = 0; cyc(12); ser_rx_in = 1; cyc(2);
    chk("R4 unselected line ignored", pd_active, 1);
    wsrc_sel = 2'b10; ser_rx_in = 0; cyc(12); ser_rx_in = 1; cyc(2);
    chk("R3 late select change ignored", pd_active, 1);
    pd_req = 1; cyc(1); pd_req = 0; cyc(2);
    chk("R11 request in sleep ignored", clk_en, 0);
    ext_irq_in = 0; cyc(QUAL + 2); ext_irq_in = 1; cyc(1);
    chk("R6 fast wake holds pins", hold_pins, 1);
    wait_run();
    chk("R6 fast wake no flag", wake_flag, 0);

    vreg_ok = 0;
    sleep(2'b11, 1); cyc(ENTRY + 3);
    ser_rx_in = 0; cyc(QUAL + 1); ser_rx_in = 1; cyc(1);
    chk("R4 either line wakes", pd_active, 0);
    chk("R7 reset path asserts reset", sys_rst, 1);
    cyc(60);
    chk("R8 regulator not ready holds", clk_en, 0);
    pd_req = 1; cyc(1); pd_req = 0;
    vreg_ok = 1; flash_rdy = 0; cyc(80);
    chk("R8 flash not ready holds", sys_rst, 1);
    flash_rdy = 1;
    wait_run();
    chk("R7 flag set after full start", wake_flag, 1);
    cyc(8);
    chk("R11 stale request ignored", pd_active, 0);
    chk("R10 flag sticky", wake_flag, 1);
    wkflag_clr = 1; cyc(1); wkflag_clr = 0; cyc(1);
    chk("R10 flag cleared by write", wake_flag, 0);

    pll_lock = 0;
    sleep(2'b01, 0); cyc(ENTRY + 3);
    ext_irq_in = 0; cyc(QUAL + 1); ext_irq_in = 1;
    wait_run();
    chk("R8 pll timeout resumes", clk_en, 1);
    pll_lock = 1;

    sleep(2'b00, 0); cyc(ENTRY + 3);
    ext_irq_in = 0; ser_rx_in = 0; cyc(20); ext_irq_in = 1; ser_rx_in = 1;
    chk("R4 no source stays asleep", pd_active, 1);
    hw_rst = 1; cyc(1); hw_rst = 0;
    @(negedge clk); chk("R9 hw reset forces reset path", sys_rst, 1);
    wait_run();
    chk("R9 hw reset leaves flag clear", wake_flag, 0);

    sleep(2'b10, 1); cyc(ENTRY + 3);
    ser_rx_in = 0; cyc(QUAL + 1); ser_rx_in = 1; cyc(3);
    hw_rst = 1; cyc(1); hw_rst = 0;
    wait_run();
    chk("R9 hw reset aborts wake", wake_flag, 0);
    cyc(5);
    finish_run();
  end
endmodule